// File: doc/BRIEF.md
# Ethernet MAC Transmit Word-to-Serial Path

This block is the transmit data path of one 10 Mb/s Ethernet MAC port. A DMA engine in the internal clock domain pushes 32-bit words into an eight-word (32-byte) dual-clock buffer. The transceiver's own transmit clock drains the buffer, splits each word into bytes and shifts every byte out as a serial bit stream. A transmit-enable output frames the stream. Preamble, CRC and line coding are added elsewhere.

A frame does not begin until a separate CSMA/CD timing block raises `start_ok`, which signals that deference and the interframe gap have elapsed. The last word of a frame is written with `wr_last` and carries a count of how many of its bytes are valid. If the buffer runs dry partway through a frame, the frame is cut off, a one-cycle underrun pulse is raised, and the remaining words of that frame are dropped.

The serializer is a state machine with five states:
- `S_IDLE`: waiting for data. It moves to `S_ARMED` when the buffer is not empty.
- `S_ARMED`: waiting for the gate. It moves to `S_SHIFT` when `start_ok` is high, and the first word is popped at that point.
- `S_SHIFT`: shifting bits out. At the last bit of a word it does one of three things:
  - returns to `S_IDLE` if the word ended the frame;
  - pops the next word and stays in `S_SHIFT` if one is waiting;
  - goes to `S_ABORT` if the buffer is empty.
- `S_ABORT`: lasts one cycle and raises the underrun pulse, then always moves to `S_FLUSH`.
- `S_FLUSH`: discards words until it pops one marked as last, then returns to `S_IDLE`.

Top module: `mac_tx_serial_path`

## Requirements
- R1: While reset is held and after reset is released, `tx_en`, `txd` and `tx_underrun` are 0, `wr_full` is 0, and no bit is sent until a word is written.
- R2: A word is taken on a `clk_sys` edge when `wr_en` is 1 and `wr_full` is 0. `wr_full` is 1 once eight words are held and unread. A write made while `wr_full` is 1 is ignored and never transmitted.
- R3: Within a word, bits 7:0 are sent first, then 15:8, 23:16 and 31:24. Each byte is sent least significant bit first, one bit per `clk_tx` cycle.
- R4: A word written with `wr_last`=1 and `wr_bytes`=k sends k+1 bytes: lanes 0 to k, so code 0 means one byte and code 3 means four. A word without `wr_last` always sends all four bytes.
- R5: A frame starts only from the `S_ARMED` state in a `clk_tx` cycle where `start_ok` is 1, and `tx_en` rises at the next edge. While `start_ok` stays 0, nothing is sent. Once a frame has started, `start_ok` has no effect on it.
- R6: `tx_en` is 1 without a break from the first bit of a frame to its last bit. It is 0 for at least one cycle between frames. `txd` is 0 whenever `tx_en` is 0.
- R7: If a word that is not the last one ends while the buffer is empty, the following happens:
  - `tx_en` drops;
  - `tx_underrun` pulses for exactly one `clk_tx` cycle;
  - every further word up to and including the next `wr_last` word is discarded without being sent.
- R8: Words cross between `clk_sys` and `clk_tx` through Gray-coded pointers with two-flop synchronizers. Data arrives intact and in order for unrelated clock frequencies, and the read side never pops while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Internal clock, write side |
| clk_tx | input | 1 | Transceiver transmit clock, read and serial side |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write request for one word |
| wr_data | input | 32 | Word to transmit, lane 0 in bits 7:0 |
| wr_last | input | 1 | Marks the final word of a frame |
| wr_bytes | input | 2 | Valid bytes minus one in the final word |
| wr_full | output | 1 | Buffer holds eight words; writes are ignored |
| start_ok | input | 1 | Deference/interframe-gap gate, `clk_tx` domain |
| tx_en | output | 1 | Transmit enable for the serial stream |
| txd | output | 1 | Serial transmit data |
| tx_underrun | output | 1 | One-cycle pulse when a frame is aborted for lack of data |

## Verification
The assertions check the following local rules on every cycle:
- a full buffer never takes a write;
- every rise of `tx_en` is preceded by an open gate;
- `txd` stays quiet while `tx_en` is low;
- the underrun pulse lasts one cycle and closes an active frame;
- the read side never pops an empty buffer.

Some behaviours can only be shown by the bench scenarios: the exact bit order across lanes, the truncation of the final word for each byte-count code, continuity of `tx_en` across word boundaries, the gate holding a full buffer back, and the silent discard of the words after an underrun. The bench shows these by comparing every transmitted bit with a queue-based model.

// File: rtl/txp_pkg.sv
package txp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_SHIFT,
        S_ABORT,
        S_FLUSH
    } ser_state_t;

endpackage

// File: rtl/txp_ptr_sync.sv
module txp_ptr_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/txp_async_fifo.sv
module txp_async_fifo #(
    parameter int ENTRY_W = 35,
    parameter int DEPTH   = 8
) (
    input  logic               wclk,
    input  logic               rclk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ENTRY_W-1:0] wr_entry,
    output logic               wr_full,
    output logic               wr_accept,
    input  logic               rd_pop,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic               rd_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rgray_w;
    logic [PW-1:0] rbin, rgray, wgray_r;

    // write domain
    assign wr_full   = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    assign wr_accept = wr_en && !wr_full;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_accept) begin
            wbin  <= wbin + PW'(1);
            wgray <= to_gray(wbin + PW'(1));
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_accept) begin
            mem[wbin[AW-1:0]] <= wr_entry;
        end
    end

    txp_ptr_sync #(.W(PW)) u_rd2wr (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_w)
    );

    // read domain
    assign rd_empty = (rgray == wgray_r);
    assign rd_entry = mem[rbin[AW-1:0]];

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_pop) begin
            rbin  <= rbin + PW'(1);
            rgray <= to_gray(rbin + PW'(1));
        end
    end

    txp_ptr_sync #(.W(PW)) u_wr2rd (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_r)
    );

endmodule

// File: rtl/txp_serializer.sv
module txp_serializer
    import txp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int LW    = $clog2(LANES),
    localparam int BW    = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              buf_empty,
    input  logic [DATA_W-1:0] buf_word,
    input  logic              buf_last,
    input  logic [LW-1:0]     buf_lanes,
    output logic              pop,
    output logic              tx_en,
    output logic              txd,
    output logic              tx_underrun
);

    ser_state_t        state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [BW-1:0]     bit_cnt;
    logic [LW-1:0]     lane_cnt;
    logic [LW-1:0]     lane_stop;
    logic              word_last;
    logic              word_done;
    logic              load;

    assign word_done = (bit_cnt == BW'(BYTE_W - 1)) && (lane_cnt == lane_stop);

    // next state and buffer pops
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        pop      = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (!buf_empty) state_nx = S_ARMED;
            end
            S_ARMED: begin
                if (start_ok && !buf_empty) begin
                    load     = 1'b1;
                    pop      = 1'b1;
                    state_nx = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (word_done) begin
                    if (word_last) begin
                        state_nx = S_IDLE;
                    end else if (!buf_empty) begin
                        load = 1'b1;
                        pop  = 1'b1;
                    end else begin
                        state_nx = S_ABORT;
                    end
                end
            end
            S_ABORT: begin
                state_nx = S_FLUSH;
            end
            S_FLUSH: begin
                if (!buf_empty) begin
                    pop = 1'b1;
                    if (buf_last) state_nx = S_IDLE;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            lane_cnt  <= '0;
            lane_stop <= '0;
            word_last <= 1'b0;
        end else if (load) begin
            shreg     <= buf_word;
            bit_cnt   <= '0;
            lane_cnt  <= '0;
            lane_stop <= buf_last ? buf_lanes : LW'(LANES - 1);
            word_last <= buf_last;
        end else if (state == S_SHIFT) begin
            shreg   <= shreg >> 1;
            bit_cnt <= bit_cnt + BW'(1);
            if (bit_cnt == BW'(BYTE_W - 1)) lane_cnt <= lane_cnt + LW'(1);
        end
    end

    // outputs
    always_comb begin
        tx_en       = (state == S_SHIFT);
        txd         = tx_en & shreg[0];
        tx_underrun = (state == S_ABORT);
    end

endmodule

// File: rtl/mac_tx_serial_path.sv
module mac_tx_serial_path #(
    parameter int DATA_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int DEPTH_WORDS = 8,
    localparam int LANES      = DATA_W / BYTE_W,
    localparam int LW         = $clog2(LANES)
) (
    input  logic              clk_sys,
    input  logic              clk_tx,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic [LW-1:0]     wr_bytes,
    output logic              wr_full,
    input  logic              start_ok,
    output logic              tx_en,
    output logic              txd,
    output logic              tx_underrun
);

    localparam int ENTRY_W = DATA_W + 1 + LW;

    logic [ENTRY_W-1:0] wr_entry;
    logic [ENTRY_W-1:0] rd_entry;
    logic               wr_accept;
    logic               buf_pop;
    logic               buf_empty;

    assign wr_entry = {wr_last, wr_bytes, wr_data};

    txp_async_fifo #(
        .ENTRY_W (ENTRY_W),
        .DEPTH   (DEPTH_WORDS)
    ) u_buf (
        .wclk      (clk_sys),
        .rclk      (clk_tx),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .wr_full   (wr_full),
        .wr_accept (wr_accept),
        .rd_pop    (buf_pop),
        .rd_entry  (rd_entry),
        .rd_empty  (buf_empty)
    );

    txp_serializer #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_ser (
        .clk         (clk_tx),
        .rst_n       (rst_n),
        .start_ok    (start_ok),
        .buf_empty   (buf_empty),
        .buf_word    (rd_entry[DATA_W-1:0]),
        .buf_last    (rd_entry[ENTRY_W-1]),
        .buf_lanes   (rd_entry[DATA_W +: LW]),
        .pop         (buf_pop),
        .tx_en       (tx_en),
        .txd         (txd),
        .tx_underrun (tx_underrun)
    );

endmodule

// File: rtl/mac_tx_serial_path_chk.sv
module mac_tx_serial_path_chk (
    input logic clk_sys,
    input logic clk_tx,
    input logic rst_n,
    input logic wr_full,
    input logic wr_accept,
    input logic start_ok,
    input logic tx_en,
    input logic txd,
    input logic tx_underrun,
    input logic buf_pop,
    input logic buf_empty
);

    // R2: nothing enters a full buffer
    a_r2_full_blocks_write: assert property (@(posedge clk_sys) disable iff (!rst_n)
        wr_full |-> !wr_accept);

    // R5: a frame only opens after the gate was seen high
    a_r5_start_needs_gate: assert property (@(posedge clk_tx) disable iff (!rst_n)
        $rose(tx_en) |-> $past(start_ok));

    // R6: serial line quiet outside a frame
    a_r6_txd_quiet: assert property (@(posedge clk_tx) disable iff (!rst_n)
        !tx_en |-> !txd);

    // R7: underrun is a single-cycle pulse
    a_r7_underrun_pulse: assert property (@(posedge clk_tx) disable iff (!rst_n)
        tx_underrun |=> !tx_underrun);

    // R7: underrun closes a frame that was running
    a_r7_underrun_ends_frame: assert property (@(posedge clk_tx) disable iff (!rst_n)
        tx_underrun |-> ($past(tx_en) && !tx_en));

    // R8: read side never pops an empty buffer
    a_r8_no_pop_empty: assert property (@(posedge clk_tx) disable iff (!rst_n)
        buf_pop |-> !buf_empty);

endmodule

bind mac_tx_serial_path mac_tx_serial_path_chk u_chk (
    .clk_sys     (clk_sys),
    .clk_tx      (clk_tx),
    .rst_n       (rst_n),
    .wr_full     (wr_full),
    .wr_accept   (wr_accept),
    .start_ok    (start_ok),
    .tx_en       (tx_en),
    .txd         (txd),
    .tx_underrun (tx_underrun),
    .buf_pop     (buf_pop),
    .buf_empty   (buf_empty)
);

// File: tb/sim_mac_tx_serial_path.sv
`timescale 1ns/1ps
module sim_mac_tx_serial_path;

    logic        clk_sys = 1'b0;
    logic        clk_tx  = 1'b0;
    logic        rst_n   = 1'b0;
    logic        wr_en   = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_last = 1'b0;
    logic [1:0]  wr_bytes = '0;
    logic        start_ok = 1'b0;
    logic        wr_full, tx_en, txd, tx_underrun;

    always #2.5 clk_sys = ~clk_sys;   // 200 MHz
    always #8.5 clk_tx  = ~clk_tx;    // unrelated transmit clock

    mac_tx_serial_path u0 (
        .clk_sys     (clk_sys),
        .clk_tx      (clk_tx),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .wr_last     (wr_last),
        .wr_bytes    (wr_bytes),
        .wr_full     (wr_full),
        .start_ok    (start_ok),
        .tx_en       (tx_en),
        .txd         (txd),
        .tx_underrun (tx_underrun)
    );

    int checks = 0;
    int fails  = 0;
    bit exp_bits[$];
    int frame_len[$];
    int left = 0;
    bit active = 1'b0;
    bit ended_last = 1'b0;
    int underruns = 0;
    bit e;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // reference model: compares every transmit clock
    always @(negedge clk_tx) begin
        if (rst_n) begin
            if (tx_underrun) underruns++;
            if (tx_en) begin
                if (!active) begin
                    check(!ended_last, "R6", "no idle cycle between frames", 1, 0);
                    if (frame_len.size() == 0) begin
                        check(1'b0, "R5", "tx_en with no frame expected", 1, 0);
                    end else begin
                        left   = frame_len.pop_front();
                        active = 1'b1;
                    end
                end
                if (active) begin
                    e = exp_bits.pop_front();
                    check(txd == e, "R3", "serial bit", txd, e);
                    left--;
                    if (left == 0) active = 1'b0;
                end
            end else begin
                if (active) check(1'b0, "R6", "tx_en dropped inside frame", 0, 1);
                check(txd == 1'b0, "R6", "txd while idle", txd, 0);
            end
            ended_last = tx_en && !active;
        end
    end

    task automatic put_word(input logic [31:0] d, input bit last,
                            input logic [1:0] code, input bit sent);
        int n;
        @(negedge clk_sys);
        while (wr_full) @(negedge clk_sys);
        wr_en = 1'b1; wr_data = d; wr_last = last; wr_bytes = code;
        @(negedge clk_sys);
        wr_en = 1'b0; wr_last = 1'b0;
        if (sent) begin
            n = last ? (int'(code) + 1) * 8 : 32;
            for (int i = 0; i < n; i++) exp_bits.push_back(d[i]);
        end
    endtask

    task automatic send_frame(input int nwords, input logic [1:0] code,
                              input logic [31:0] seed);
        logic [31:0] w;
        frame_len.push_back((nwords - 1) * 32 + (int'(code) + 1) * 8);
        for (int i = 0; i < nwords; i++) begin
            w = seed ^ (32'(i) * 32'h01030507);
            put_word(w, i == nwords - 1, code, 1'b1);
        end
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((exp_bits.size() != 0 || active) && t < 20000) begin
            @(negedge clk_tx);
            t++;
        end
        repeat (4) @(negedge clk_tx);
        check(exp_bits.size() == 0 && frame_len.size() == 0, req,
              "frame fully sent", exp_bits.size(), 0);
    endtask

    task automatic quiet_window(input int cycles, input string req, input string what);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk_tx);
            if (tx_en) seen++;
        end
        check(seen == 0, req, what, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk_sys);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk_sys);
        check(tx_en == 1'b0 && txd == 1'b0, "R1", "tx idle in reset", tx_en, 0);
        check(tx_underrun == 1'b0, "R1", "underrun in reset", tx_underrun, 0);
        check(wr_full == 1'b0, "R1", "full in reset", wr_full, 0);
        rst_n = 1'b1;
        quiet_window(20, "R1", "output after reset without data");

        // R3 R4: frames with each final-word byte count
        start_ok = 1'b1;
        send_frame(3, 2'd3, 32'hA1B2C3D4);
        drain("R4");
        send_frame(1, 2'd0, 32'h0000005A);
        drain("R4");
        send_frame(2, 2'd1, 32'h8001F00F);
        drain("R4");
        send_frame(2, 2'd2, 32'h13579BDF);
        drain("R3");

        // R2 R5: gate closed, fill buffer, ignored write
        start_ok = 1'b0;
        send_frame(8, 2'd1, 32'hCAFE0123);
        check(wr_full == 1'b1, "R2", "full after eight words", wr_full, 1);
        @(negedge clk_sys);
        wr_en = 1'b1; wr_data = 32'hDEADBEEF; wr_last = 1'b1; wr_bytes = 2'd3;
        @(negedge clk_sys);
        wr_en = 1'b0; wr_last = 1'b0;
        quiet_window(80, "R5", "transmit while gate closed");
        start_ok = 1'b1;
        drain("R2");
        quiet_window(60, "R2", "write made while full leaked out");
        check(wr_full == 1'b0, "R2", "full after drain", wr_full, 0);

        // R5: gate dropped after start has no effect
        start_ok = 1'b0;
        send_frame(3, 2'd3, 32'h5EED5EED);
        start_ok = 1'b1;
        @(posedge tx_en);
        start_ok = 1'b0;
        drain("R5");
        start_ok = 1'b1;

        // R7: underrun, then flush of the rest of the frame
        frame_len.push_back(32);
        put_word(32'h0F0F3C3C, 1'b0, 2'd0, 1'b1);
        drain("R7");
        repeat (10) @(negedge clk_tx);
        check(underruns == 1, "R7", "underrun pulses", underruns, 1);
        put_word(32'h77777777, 1'b0, 2'd0, 1'b0);
        put_word(32'h12345678, 1'b1, 2'd3, 1'b0);
        quiet_window(80, "R7", "flushed words transmitted");
        check(underruns == 1, "R7", "underrun pulses after flush", underruns, 1);

        // R8: normal traffic after recovery, back-to-back frames
        send_frame(4, 2'd2, 32'h2468ACE0);
        send_frame(2, 2'd0, 32'h1111FFFF);
        drain("R8");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule